// File: doc/BRIEF.md
# Transmit Self-Test Pattern Source

This block sits in front of a channel's character encoder and, when its self-test latch is set, replaces the user byte and control inputs with a repeating pseudo-random character stream. The stream comes from a 9-bit maximal-length shift register whose states are mapped to data bytes and to special-code indices. One pass of the stream reaches every one of the 256 data bytes and every one of the 32 special-code indices. The special-code indices include the explicit violation symbols that the encoder produces. A receiver running an identical generator can lock to the stream and compare it character by character. To help that receiver lock, the block outputs a one-cycle marker on the first character of every pass.

When the receive side of the link runs from the reference clock, each pass opens with a 16-character word-sync burst. The burst gives elasticity buffers time to align before the pseudo-random part of the pass begins. The latch is written through a single-bit configuration port and is cleared by reset. When self-test is off, the user byte and control pass through with one register of delay.

Top module: `bist_pattern_gen`

## Requirements
- R1: While reset is low, and after it, `bist_on` is 0 and the outputs `tx_data`, `tx_ctl`, `tx_special` and `tx_pass_start` are all 0.
- R2: A clock edge with `cfg_wr` high loads `cfg_wdata` into the self-test latch, and `bist_on` shows the new value after that edge. Edges with `cfg_wr` low leave the latch unchanged.
- R3: With the latch clear, each edge copies `usr_data` to `tx_data` and `usr_ctl` to `tx_ctl`. It sets `tx_special` when `usr_ctl` is not 2'b00, and `tx_pass_start` stays 0.
- R4: With the latch set, `usr_data` and `usr_ctl` have no effect on any output. The control code 2'b01 (fill) never appears on the outputs.
- R5: The generator state s[8:0] steps as s_next = {s[7:0], s[8]^s[4]}, which realises x^9+x^5+1. Every pass starts from the seed 9'h0AA. With the latch set by a write at edge W, the first generated character appears after edge W+1.
- R6: A state with s[8]=1 and s[7:5]=3'b111 gives a special character: `tx_ctl`=2'b10, `tx_special`=1 and `tx_data`={3'b000, s[4:0]}. Any other state gives a data character: `tx_ctl`=2'b00, `tx_special`=0 and `tx_data`=s[7:0].
- R7: With reference-clock receive mode clear, a pass is 511 characters, one for each state from the seed onward. `tx_pass_start` is 1 on the first character of each pass and 0 on all other characters.
- R8: Each complete pass, in either mode, delivers all 256 data byte values and all 32 special-code indices.
- R9: With reference-clock receive mode set, a pass is 526 characters. The first 16 are word-sync characters (`tx_data`=8'hBC, `tx_ctl`=2'b11, `tx_special`=1). These are followed by the characters of the first 510 generator states.
- R10: `cfg_refclk_rx` is sampled only on the edge that emits the first character of a pass. Changing it during a pass affects only the following pass.
- R11: Clearing the latch during a pass returns the outputs to the user inputs on the very next character. Setting the latch again restarts a pass at the seed, with `tx_pass_start` asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the self-test latch |
| cfg_wdata | input | 1 | Value written to the self-test latch |
| cfg_refclk_rx | input | 1 | Receive side uses reference clock; add word-sync burst to each pass |
| usr_data | input | 8 | User character byte |
| usr_ctl | input | 2 | User control code (00 data, 01 fill, 10 special, 11 word sync) |
| tx_data | output | 8 | Character byte to the encoder |
| tx_ctl | output | 2 | Control code to the encoder |
| tx_special | output | 1 | Encode the byte as a special character |
| tx_pass_start | output | 1 | High on the first character of every self-test pass |
| bist_on | output | 1 | Current state of the self-test latch |

## Verification
A configuration write takes effect on `bist_on` right after the edge that samples it. The first generated character, together with the pass-start marker, follows one edge later. User inputs appear on the outputs one edge after they are sampled, and a cleared latch hands the outputs back on the edge that follows the clearing write. The bench drives inputs one nanosecond after a rising edge and reads outputs one nanosecond after the next rising edge. It advances a requirement-level model of the generator by exactly one character for every edge in which the latch was set, so each comparison lands on the character that the model places in that slot.

// File: rtl/bpg_pkg.sv
`timescale 1ns/1ps
package bpg_pkg;

    localparam int CHAR_W = 8;
    localparam int CTL_W  = 2;

    typedef enum logic [CTL_W-1:0] {
        CTL_DATA    = 2'b00,
        CTL_FILL    = 2'b01,
        CTL_SPECIAL = 2'b10,
        CTL_WSYNC   = 2'b11
    } ctl_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic [CTL_W-1:0]  ctl;
        logic              special;
    } txchar_t;

endpackage

// File: rtl/bpg_lfsr_step.sv
`timescale 1ns/1ps
// One Fibonacci shift step: the feedback bit enters at the low end.
module bpg_lfsr_step #(
    parameter int W     = 9,
    parameter int TAP_A = 8,
    parameter int TAP_B = 4
) (
    input  logic [W-1:0] state,
    output logic [W-1:0] state_next
);
    always_comb begin
        state_next = {state[W-2:0], state[TAP_A] ^ state[TAP_B]};
    end
endmodule

// File: rtl/bpg_char_map.sv
`timescale 1ns/1ps
// Maps a generator state onto a data or special character.
module bpg_char_map
    import bpg_pkg::*;
#(
    parameter int W      = 9,
    parameter int MARK_W = 3
) (
    input  logic [W-1:0] state,
    output txchar_t      chr
);
    localparam int CODE_W = W - 1 - MARK_W;

    logic is_spec;

    always_comb begin
        is_spec = state[W-1] & (&state[W-2 -: MARK_W]);
        if (is_spec) begin
            chr.data    = CHAR_W'(state[CODE_W-1:0]);
            chr.ctl     = CTL_SPECIAL;
            chr.special = 1'b1;
        end else begin
            chr.data    = state[CHAR_W-1:0];
            chr.ctl     = CTL_DATA;
            chr.special = 1'b0;
        end
    end
endmodule

// File: rtl/bpg_pass_seq.sv
`timescale 1ns/1ps
// Decodes the character index within a pass.
module bpg_pass_seq #(
    parameter int IDX_W    = 10,
    parameter int SYNC_LEN = 16,
    parameter int LEN_RAW  = 511,
    parameter int LEN_SYNC = 526
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             sync_mode,
    output logic             in_sync,
    output logic             last
);
    localparam logic [IDX_W-1:0] SYNC_END  = IDX_W'(SYNC_LEN);
    localparam logic [IDX_W-1:0] LAST_RAW  = IDX_W'(LEN_RAW - 1);
    localparam logic [IDX_W-1:0] LAST_SYNC = IDX_W'(LEN_SYNC - 1);

    always_comb begin
        in_sync = sync_mode && (idx < SYNC_END);
        last    = sync_mode ? (idx == LAST_SYNC) : (idx == LAST_RAW);
    end
endmodule

// File: rtl/bist_pattern_gen.sv
`timescale 1ns/1ps
module bist_pattern_gen
    import bpg_pkg::*;
#(
    parameter int                 LFSR_W    = 9,
    parameter int                 TAP_A     = 8,
    parameter int                 TAP_B     = 4,
    parameter logic [LFSR_W-1:0]  SEED      = 9'h0AA,
    parameter int                 MARK_W    = 3,
    parameter int                 SYNC_LEN  = 16,
    parameter logic [CHAR_W-1:0]  SYNC_BYTE = 8'hBC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_wdata,
    input  logic              cfg_refclk_rx,
    input  logic [CHAR_W-1:0] usr_data,
    input  logic [CTL_W-1:0]  usr_ctl,
    output logic [CHAR_W-1:0] tx_data,
    output logic [CTL_W-1:0]  tx_ctl,
    output logic              tx_special,
    output logic              tx_pass_start,
    output logic              bist_on
);
    localparam int LEN_RAW  = (1 << LFSR_W) - 1;
    localparam int LEN_SYNC = SYNC_LEN + LEN_RAW - 1;
    localparam int IDX_W    = $clog2(LEN_SYNC + 1);

    typedef struct packed {
        logic              en;
        logic              mode;
        logic [IDX_W-1:0]  idx;
        logic [LFSR_W-1:0] lfsr;
        txchar_t           out;
        logic              sop;
    } state_t;

    state_t q, d;

    logic [LFSR_W-1:0] lfsr_next;
    txchar_t           gen_chr;
    logic              eff_mode;
    logic              in_sync;
    logic              last;

    // The mode input counts only on the first character of a pass.
    always_comb begin
        eff_mode = (q.idx == '0) ? cfg_refclk_rx : q.mode;
    end

    bpg_lfsr_step #(
        .W     (LFSR_W),
        .TAP_A (TAP_A),
        .TAP_B (TAP_B)
    ) u_step (
        .state      (q.lfsr),
        .state_next (lfsr_next)
    );

    bpg_char_map #(
        .W      (LFSR_W),
        .MARK_W (MARK_W)
    ) u_map (
        .state (q.lfsr),
        .chr   (gen_chr)
    );

    bpg_pass_seq #(
        .IDX_W    (IDX_W),
        .SYNC_LEN (SYNC_LEN),
        .LEN_RAW  (LEN_RAW),
        .LEN_SYNC (LEN_SYNC)
    ) u_seq (
        .idx       (q.idx),
        .sync_mode (eff_mode),
        .in_sync   (in_sync),
        .last      (last)
    );

    always_comb begin
        d     = q;
        d.sop = 1'b0;
        if (cfg_wr) begin
            d.en = cfg_wdata;
        end
        if (q.en) begin
            d.mode = eff_mode;
            d.sop  = (q.idx == '0);
            if (in_sync) begin
                d.out.data    = SYNC_BYTE;
                d.out.ctl     = CTL_WSYNC;
                d.out.special = 1'b1;
            end else begin
                d.out  = gen_chr;
                d.lfsr = lfsr_next;
            end
            if (last) begin
                d.idx  = '0;
                d.lfsr = SEED;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end else begin
            d.mode        = 1'b0;
            d.idx         = '0;
            d.lfsr        = SEED;
            d.out.data    = usr_data;
            d.out.ctl     = usr_ctl;
            d.out.special = (usr_ctl != CTL_DATA);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.lfsr <= SEED;
        end else begin
            q <= d;
        end
    end

    assign tx_data       = q.out.data;
    assign tx_ctl        = q.out.ctl;
    assign tx_special    = q.out.special;
    assign tx_pass_start = q.sop;
    assign bist_on       = q.en;

endmodule

// File: rtl/bpg_checker.sv
`timescale 1ns/1ps
module bpg_checker #(
    parameter int         MAX_GAP   = 526,
    parameter logic [7:0] SYNC_BYTE = 8'hBC
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic       cfg_wdata,
    input logic [7:0] usr_data,
    input logic [1:0] usr_ctl,
    input logic [7:0] tx_data,
    input logic [1:0] tx_ctl,
    input logic       tx_special,
    input logic       tx_pass_start,
    input logic       bist_on
);
    logic [10:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (tx_pass_start || !bist_on) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !bist_on);

    assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cfg_wr) |-> bist_on == $past(cfg_wdata));

    assert_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(bist_on) |->
            tx_data == $past(usr_data) && tx_ctl == $past(usr_ctl) && !tx_pass_start);

    assert_no_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bist_on) |-> tx_ctl != 2'b01);

    assert_special_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bist_on) && tx_ctl == 2'b10 |->
            tx_data[7:5] == 3'b000 && tx_special);

    assert_start_in_bist_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pass_start |-> $past(bist_on));

    assert_pass_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= 11'(MAX_GAP));

    assert_sync_char_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bist_on) && tx_ctl == 2'b11 |->
            tx_data == SYNC_BYTE && tx_special);

endmodule

bind bist_pattern_gen bpg_checker #(
    .MAX_GAP   (526),
    .SYNC_BYTE (8'hBC)
) u_bpg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_wdata     (cfg_wdata),
    .usr_data      (usr_data),
    .usr_ctl       (usr_ctl),
    .tx_data       (tx_data),
    .tx_ctl        (tx_ctl),
    .tx_special    (tx_special),
    .tx_pass_start (tx_pass_start),
    .bist_on       (bist_on)
);

// File: tb/bist_pattern_gen_bench.sv
`timescale 1ns/1ps
module bist_pattern_gen_bench;

    localparam real CLK_PERIOD = 4.0;
    localparam logic [8:0] SEED = 9'h0AA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_wdata = 1'b0;
    logic       cfg_refclk_rx = 1'b0;
    logic [7:0] usr_data = 8'h00;
    logic [1:0] usr_ctl = 2'b00;
    logic [7:0] tx_data;
    logic [1:0] tx_ctl;
    logic       tx_special;
    logic       tx_pass_start;
    logic       bist_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model of the pass
    int         m_idx;
    logic [8:0] m_lfsr;
    bit         m_mode;
    bit         data_seen [256];
    bit         spec_seen [32];
    logic [7:0] noise = 8'h3C;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    bist_pattern_gen u_bist_pattern_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr        (cfg_wr),
        .cfg_wdata     (cfg_wdata),
        .cfg_refclk_rx (cfg_refclk_rx),
        .usr_data      (usr_data),
        .usr_ctl       (usr_ctl),
        .tx_data       (tx_data),
        .tx_ctl        (tx_ctl),
        .tx_special    (tx_special),
        .tx_pass_start (tx_pass_start),
        .bist_on       (bist_on)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] step(input logic [8:0] s);
        return {s[7:0], s[8] ^ s[4]};
    endfunction

    function automatic logic [11:0] char_of(input logic [8:0] s);
        // {data, ctl, special, sop=0} packed as data[11:4] ctl[3:2] special[1]
        if (s[8] && s[7:5] == 3'b111) return {3'b000, s[4:0], 2'b10, 1'b1, 1'b0};
        return {s[7:0], 2'b00, 1'b0, 1'b0};
    endfunction

    task automatic clear_cov();
        for (int i = 0; i < 256; i++) data_seen[i] = 1'b0;
        for (int i = 0; i < 32; i++) spec_seen[i] = 1'b0;
    endtask

    task automatic check_cov(input string req);
        int nd = 0;
        int ns = 0;
        for (int i = 0; i < 256; i++) if (data_seen[i]) nd++;
        for (int i = 0; i < 32; i++) if (spec_seen[i]) ns++;
        check(nd == 256, req, nd, 256);
        check(ns == 32, req, ns, 32);
    endtask

    task automatic model_start();
        m_idx  = 0;
        m_lfsr = SEED;
        m_mode = 1'b0;
    endtask

    // Follow n generated characters; user inputs are scrambled to show they are ignored (R4).
    task automatic follow(input int n);
        for (int k = 0; k < n; k++) begin
            logic [11:0] exp;
            logic [11:0] act;
            bit sync;
            bit last;
            if (m_idx == 0) m_mode = cfg_refclk_rx;
            sync = m_mode && (m_idx < 16);
            exp  = sync ? {8'hBC, 2'b11, 1'b1, 1'b0} : char_of(m_lfsr);
            exp[0] = (m_idx == 0);
            last = m_mode ? (m_idx == 525) : (m_idx == 510);
            noise    = {noise[6:0], noise[7] ^ noise[5] ^ noise[4] ^ noise[3]};
            usr_data = noise;
            usr_ctl  = noise[1:0];
            tick();
            act = {tx_data, tx_ctl, tx_special, tx_pass_start};
            check(act == exp, sync ? "R9 sync slot" : (exp[0] ? "R7 pass start" : "R6/R4 char"),
                  32'(act), 32'(exp));
            if (!sync) begin
                if (tx_ctl == 2'b00) data_seen[tx_data] = 1'b1;
                else if (tx_ctl == 2'b10) spec_seen[tx_data[4:0]] = 1'b1;
                m_lfsr = step(m_lfsr);
            end
            if (last) begin
                m_idx  = 0;
                m_lfsr = SEED;
            end else begin
                m_idx++;
            end
        end
    endtask

    task automatic write_latch(input bit v);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_wr    = 1'b0;
        cfg_wdata = 1'b0;
        check(bist_on == v, "R2 latch write", 32'(bist_on), 32'(v));
    endtask

    task automatic test_reset();
        tick();
        check({bist_on, tx_data, tx_ctl, tx_special, tx_pass_start} == '0, "R1 reset state",
              32'({bist_on, tx_data, tx_ctl, tx_special, tx_pass_start}), 0);
        rst_n = 1'b1;
        tick();
        check(bist_on == 1'b0, "R1 off after reset", 32'(bist_on), 0);
    endtask

    task automatic test_passthrough();
        logic [9:0] pats [4] = '{10'h0_00, 10'h1_FF, 10'h2_5A, 10'h3_A5};
        for (int i = 0; i < 4; i++) begin
            usr_data = pats[i][7:0];
            usr_ctl  = pats[i][9:8];
            tick();
            check({tx_data, tx_ctl, tx_special, tx_pass_start} ==
                  {pats[i][7:0], pats[i][9:8], pats[i][9:8] != 2'b00, 1'b0},
                  "R3 passthrough", 32'({tx_data, tx_ctl, tx_special, tx_pass_start}),
                  32'({pats[i][7:0], pats[i][9:8], pats[i][9:8] != 2'b00, 1'b0}));
        end
        write_latch(1'b0);  // R2: writing zero keeps it off
        tick();
        check(bist_on == 1'b0, "R2 no write keeps state", 32'(bist_on), 0);
    endtask

    task automatic test_plain_pass();
        cfg_refclk_rx = 1'b0;
        write_latch(1'b1);
        model_start();
        clear_cov();
        follow(1);
        // R5: first character is the seed 0x0AA as data 0xAA
        check(tx_data == 8'hAA && tx_ctl == 2'b00 && tx_pass_start, "R5 seed char",
              32'({tx_data, tx_ctl, tx_pass_start}), 32'({8'hAA, 2'b00, 1'b1}));
        follow(510);
        check_cov("R8 plain coverage");
        follow(1);
        check(tx_pass_start == 1'b1, "R7 pass length 511", 32'(tx_pass_start), 1);
        follow(40);
    endtask

    task automatic test_disable_mid();
        cfg_wr    = 1'b1;
        cfg_wdata = 1'b0;
        follow(1);   // the clearing edge still emits a generated character
        cfg_wr    = 1'b0;
        check(bist_on == 1'b0, "R2 clear latch", 32'(bist_on), 0);
        usr_data = 8'h5A;
        usr_ctl  = 2'b01;
        tick();
        check({tx_data, tx_ctl, tx_special, tx_pass_start} == {8'h5A, 2'b01, 1'b1, 1'b0},
              "R11 user restored", 32'({tx_data, tx_ctl, tx_special, tx_pass_start}),
              32'({8'h5A, 2'b01, 1'b1, 1'b0}));
        write_latch(1'b1);
        model_start();
        follow(1);
        check(tx_pass_start && tx_data == 8'hAA, "R11 restart at seed",
              32'({tx_data, tx_pass_start}), 32'({8'hAA, 1'b1}));
        follow(5);
    endtask

    task automatic test_ref_mode();
        write_latch(1'b0);
        cfg_refclk_rx = 1'b1;
        write_latch(1'b1);
        model_start();
        clear_cov();
        follow(100);
        cfg_refclk_rx = 1'b0;   // R10: must not alter the current pass
        follow(426);
        check_cov("R8 sync-mode coverage");
        follow(1);
        check(tx_pass_start == 1'b1 && tx_ctl == 2'b00, "R10 next pass plain",
              32'({tx_ctl, tx_pass_start}), 32'({2'b00, 1'b1}));
        follow(510);
        follow(1);
        check(tx_pass_start == 1'b1, "R7 plain length after switch", 32'(tx_pass_start), 1);
    endtask

    task automatic test_reset_mid();
        follow(7);
        rst_n = 1'b0;
        tick();
        check({bist_on, tx_data, tx_ctl, tx_special, tx_pass_start} == '0, "R1 reset mid-pass",
              32'({bist_on, tx_data, tx_ctl, tx_special, tx_pass_start}), 0);
        rst_n = 1'b1;
        tick();
        check(bist_on == 1'b0, "R1 stays off", 32'(bist_on), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        test_reset();
        test_passthrough();
        test_plain_pass();
        test_disable_mid();
        test_ref_mode();
        test_reset_mid();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000.0);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

endmodule